// File: doc/BRIEF.md
# Segmented Page Translation Unit

This block turns a 32-bit effective address into a 32-bit physical address. The upper four effective address bits select one of sixteen segment descriptors. Each descriptor holds a 24-bit virtual segment identifier and a flag that sends the access to a legacy direct-store I/O path instead of translating it. For an ordinary memory access, the identifier and the page index together form a 40-bit virtual address. That address is looked up in a small fully associative translation buffer. The 12-bit page offset passes through unchanged.

A lookup answers one cycle after the request. The answer is a hit with a physical address, a direct-store diversion, or a miss. A miss raises a request to an outside page-table walker and holds the virtual address until the walker answers with a page frame. The frame is written into the buffer at that edge, and the requester retries. While a walk is outstanding, new requests are not accepted. Descriptors are loaded through an index/data/write-enable port. A flush input empties the buffer in one cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset no response and no walk request is active, and the buffer is empty, so the first memory lookup misses.
- R2: Effective address bits [31:28] select the segment descriptor. A descriptor write is used by requests from the next cycle on. A request made in the same cycle as a write to its segment still sees the previous descriptor. Two segments that hold the same identifier share buffer entries.
- R3: When the selected descriptor has its direct-store flag set, the response has rsp_ds=1, rsp_hit=0 and rsp_pa equal to the effective address, and no walk is requested.
- R4: A miss raises walk_req in the cycle after the request, with walk_va = {identifier, effective address bits [27:12]}. Both hold steady until the cycle in which walk_ack is high. walk_req is low in the following cycle.
- R5: The frame on walk_ppn in the walk_ack cycle is written into the buffer at that clock edge, so a retry of the same page hits.
- R6: A hit answers one cycle after the request with rsp_valid=1, rsp_hit=1 and rsp_pa = {frame, effective address bits [11:0]}. At most one entry matches any lookup.
- R7: A request presented while walk_req is high is ignored and produces no response.
- R8: Refills fill the buffer slots in round-robin order. After a flush and 16 refills of distinct pages, a 17th refill evicts the first of them and keeps the second.
- R9: A flush pulse invalidates every entry, so later lookups of previously cached pages miss.
- R10: When a flush and walk_ack fall in the same cycle, the flush wins: the refill is discarded and the retry misses again.
- R11: Each accepted request yields exactly one response one cycle later. A miss response has rsp_hit=0, rsp_ds=0 and rsp_pa=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | Segment descriptor write strobe |
| sr_idx | input | 4 | Descriptor being written |
| sr_vsid | input | 24 | Virtual segment identifier to store |
| sr_ds | input | 1 | Direct-store flag to store |
| tlb_flush | input | 1 | Invalidate all buffer entries |
| req_valid | input | 1 | Translation request |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_ds | output | 1 | Access diverted to direct-store path |
| rsp_pa | output | 32 | Physical address (effective address for direct-store, zero on miss) |
| walk_req | output | 1 | Page-table walk needed |
| walk_va | output | 40 | Virtual address to be walked |
| walk_ack | input | 1 | Walker returns a frame |
| walk_ppn | input | 20 | Physical page frame from walker |

## Verification
The refill write and the flush can land on the same clock edge. The bench provokes this by raising tlb_flush in the same cycle as walk_ack. It judges the result at the ports: the retry of that page must miss again and start a fresh walk, and a normal walk afterwards must make it hit. A second collision puts a descriptor write in the same cycle as a request to that segment. That request must be answered with the old descriptor, and the next request with the new one.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   localparam int unsigned DEF_EA_W      = 32;
   localparam int unsigned DEF_SEL_W     = 4;
   localparam int unsigned DEF_PAGE_BITS = 12;
   localparam int unsigned DEF_VSID_W    = 24;
   localparam int unsigned DEF_PPN_W     = 20;
   localparam int unsigned DEF_ENTRIES   = 16;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_HIT  = 2'd1,
      RK_MISS = 2'd2,
      RK_DS   = 2'd3
   } rsp_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned VSID_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  widx,
   input  logic [VSID_W-1:0] wvsid,
   input  logic              wds,
   input  logic [SEL_W-1:0]  ridx,
   output logic [VSID_W-1:0] rvsid,
   output logic              rds
);
   localparam int unsigned NUM = 1 << SEL_W;

   logic [VSID_W-1:0] vsid_q [NUM];
   logic [NUM-1:0]    ds_q;

   if (SEL_W < 1 || SEL_W > 8) begin : g_bad_sel
      $error("seg_regfile: SEL_W out of range");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM; i++) vsid_q[i] <= '0;
         ds_q <= '0;
      end else if (we) begin
         vsid_q[widx] <= wvsid;
         ds_q[widx]   <= wds;
      end
   end

   assign rvsid = vsid_q[ridx];
   assign rds   = ds_q[ridx];

   // R2: a write is visible in the addressed descriptor one cycle later
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (vsid_q[$past(widx)] == $past(wvsid)) && (ds_q[$past(widx)] == $past(wds)));
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned TAG_W   = 40,
   parameter int unsigned DATA_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data
);
   localparam int unsigned IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_bad_depth
      $error("xlate_tlb: ENTRIES must be a power of two, at least 2");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] match;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [DATA_W-1:0]  dat_q [ENTRIES];
   logic [IDX_W-1:0]   ptr_q;
   logic               fill_go;

   assign fill_go = fill_en && !flush;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);
   end

   always_comb begin
      lk_data = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (match[i]) lk_data = lk_data | dat_q[i];
   end
   assign lk_hit = |match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
      end else if (fill_go) begin
         vld_q[ptr_q] <= 1'b1;
         ptr_q        <= ptr_q + IDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         tag_q[ptr_q] <= fill_tag;
         dat_q[ptr_q] <= fill_data;
      end
   end

   // R6: never more than one matching entry
   a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match));
   // R9: a flush leaves every entry invalid
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (vld_q == '0));
   // R8: each accepted refill moves the victim pointer by one slot
   a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |=> (ptr_q == IDX_W'($past(ptr_q) + IDX_W'(1))));
   // R10: a refill colliding with a flush is dropped
   a_r10_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && flush) |=> $stable(ptr_q) && (vld_q == '0));
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_xlate_pkg::*;
#(
   parameter int unsigned EA_W      = DEF_EA_W,
   parameter int unsigned SEL_W     = DEF_SEL_W,
   parameter int unsigned PAGE_BITS = DEF_PAGE_BITS,
   parameter int unsigned VSID_W    = DEF_VSID_W,
   parameter int unsigned PPN_W     = DEF_PPN_W,
   parameter int unsigned ENTRIES   = DEF_ENTRIES
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    sr_we,
   input  logic [SEL_W-1:0]                        sr_idx,
   input  logic [VSID_W-1:0]                       sr_vsid,
   input  logic                                    sr_ds,
   input  logic                                    tlb_flush,
   input  logic                                    req_valid,
   input  logic [EA_W-1:0]                         req_ea,
   output logic                                    rsp_valid,
   output logic                                    rsp_hit,
   output logic                                    rsp_ds,
   output logic [EA_W-1:0]                         rsp_pa,
   output logic                                    walk_req,
   output logic [VSID_W+EA_W-SEL_W-PAGE_BITS-1:0]  walk_va,
   input  logic                                    walk_ack,
   input  logic [PPN_W-1:0]                        walk_ppn
);
   localparam int unsigned PIDX_W = EA_W - SEL_W - PAGE_BITS;
   localparam int unsigned VA_W   = VSID_W + PIDX_W;

   if (PPN_W + PAGE_BITS != EA_W) begin : g_bad_pa
      $error("seg_xlate: frame plus offset must equal address width");
   end
   if (EA_W <= SEL_W + PAGE_BITS) begin : g_bad_split
      $error("seg_xlate: no page index bits left");
   end

   logic [VSID_W-1:0] seg_vsid;
   logic              seg_ds;
   logic [VA_W-1:0]   va_d;
   logic              tlb_hit;
   logic [PPN_W-1:0]  tlb_ppn;
   logic              accept;
   rsp_kind_e         kind_d, kind_q;
   logic [EA_W-1:0]   pa_d, pa_q;
   logic              walk_req_q;
   logic [VA_W-1:0]   walk_va_q;

   seg_regfile #(.SEL_W(SEL_W), .VSID_W(VSID_W)) u_segs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sr_we),
      .widx  (sr_idx),
      .wvsid (sr_vsid),
      .wds   (sr_ds),
      .ridx  (req_ea[EA_W-1 -: SEL_W]),
      .rvsid (seg_vsid),
      .rds   (seg_ds)
   );

   assign va_d = {seg_vsid, req_ea[EA_W-SEL_W-1:PAGE_BITS]};

   xlate_tlb #(.ENTRIES(ENTRIES), .TAG_W(VA_W), .DATA_W(PPN_W)) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (tlb_flush),
      .lk_tag    (va_d),
      .lk_hit    (tlb_hit),
      .lk_data   (tlb_ppn),
      .fill_en   (walk_req_q && walk_ack),
      .fill_tag  (walk_va_q),
      .fill_data (walk_ppn)
   );

   assign accept = req_valid && !walk_req_q;

   always_comb begin
      if (!accept)      kind_d = RK_NONE;
      else if (seg_ds)  kind_d = RK_DS;
      else if (tlb_hit) kind_d = RK_HIT;
      else              kind_d = RK_MISS;
      case (kind_d)
         RK_HIT:  pa_d = {tlb_ppn, req_ea[PAGE_BITS-1:0]};
         RK_DS:   pa_d = req_ea;
         default: pa_d = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q     <= RK_NONE;
         pa_q       <= '0;
         walk_req_q <= 1'b0;
         walk_va_q  <= '0;
      end else begin
         kind_q <= kind_d;
         pa_q   <= pa_d;
         if (walk_req_q && walk_ack) begin
            walk_req_q <= 1'b0;
         end else if (kind_d == RK_MISS) begin
            walk_req_q <= 1'b1;
            walk_va_q  <= va_d;
         end
      end
   end

   assign rsp_valid = (kind_q != RK_NONE);
   assign rsp_hit   = (kind_q == RK_HIT);
   assign rsp_ds    = (kind_q == RK_DS);
   assign rsp_pa    = pa_q;
   assign walk_req  = walk_req_q;
   assign walk_va   = walk_va_q;

   // R4: walk request and address stay put until acknowledged
   a_r4_walk_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && !walk_ack) |=> walk_req && $stable(walk_va));
   // R4: acknowledge ends the walk request
   a_r4_walk_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_req && walk_ack) |=> !walk_req);
   // R7: nothing is answered for a request seen during a walk
   a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      walk_req |=> !rsp_valid);
   // R3: direct-store answers never start a walk
   a_r3_ds_no_walk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ds |-> !walk_req);
   // R11: response flags are exclusive and only with rsp_valid
   a_r11_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_hit || rsp_ds) |-> rsp_valid && !(rsp_hit && rsp_ds));
endmodule

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
   localparam int K_HIT = 0, K_MISS = 1, K_DS = 2, K_NONE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_we = 1'b0;
   logic [3:0]  sr_idx = '0;
   logic [23:0] sr_vsid = '0;
   logic        sr_ds = 1'b0;
   logic        tlb_flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_ea = '0;
   logic        rsp_valid, rsp_hit, rsp_ds;
   logic [31:0] rsp_pa;
   logic        walk_req;
   logic [39:0] walk_va;
   logic        walk_ack = 1'b0;
   logic [19:0] walk_ppn = '0;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   typedef struct {int due; int kind; logic [31:0] pa; string req;} exp_t;
   exp_t sb [$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   seg_xlate dut (
      .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_idx(sr_idx), .sr_vsid(sr_vsid),
      .sr_ds(sr_ds), .tlb_flush(tlb_flush), .req_valid(req_valid), .req_ea(req_ea),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ds(rsp_ds), .rsp_pa(rsp_pa),
      .walk_req(walk_req), .walk_va(walk_va), .walk_ack(walk_ack), .walk_ppn(walk_ppn)
   );

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_sim();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // monitor: compare each response against the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            int   k;
            e = sb.pop_front();
            k = !rsp_valid ? K_NONE : rsp_hit ? K_HIT : rsp_ds ? K_DS : K_MISS;
            check(k == e.kind, e.req, "response kind", 64'(k), 64'(e.kind));
            check(rsp_pa == e.pa, e.req, "physical address", 64'(rsp_pa), 64'(e.pa));
         end else if (rsp_valid) begin
            check(0, "R11", "unexpected response", 64'(1), 64'(0));
         end
      end
   end

   task automatic send(logic [31:0] ea, int kind, logic [31:0] pa, string req);
      @(negedge clk);
      req_valid = 1'b1;
      req_ea    = ea;
      sb.push_back('{cyc + 1, kind, pa, req});
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic send_sw(logic [31:0] ea, int kind, logic [31:0] pa, string req,
                          logic [3:0] idx, logic [23:0] vsid, logic ds);
      @(negedge clk);
      req_valid = 1'b1; req_ea = ea;
      sr_we = 1'b1; sr_idx = idx; sr_vsid = vsid; sr_ds = ds;
      sb.push_back('{cyc + 1, kind, pa, req});
      @(negedge clk);
      req_valid = 1'b0; sr_we = 1'b0;
   endtask

   task automatic send_ign(logic [31:0] ea);
      @(negedge clk);
      req_valid = 1'b1; req_ea = ea;
      @(negedge clk);
      req_valid = 1'b0;
      check(rsp_valid == 1'b0, "R7", "request during walk answered", 64'(rsp_valid), 64'(0));
   endtask

   task automatic write_sr(logic [3:0] idx, logic [23:0] vsid, logic ds);
      @(negedge clk);
      sr_we = 1'b1; sr_idx = idx; sr_vsid = vsid; sr_ds = ds;
      @(negedge clk);
      sr_we = 1'b0;
   endtask

   task automatic walk(logic [39:0] va, logic [19:0] ppn, bit fl);
      check(walk_req == 1'b1, "R4", "walk request raised", 64'(walk_req), 64'(1));
      check(walk_va == va, "R4", "walk address", 64'(walk_va), 64'(va));
      walk_ack = 1'b1; walk_ppn = ppn; tlb_flush = fl;
      @(negedge clk);
      walk_ack = 1'b0; tlb_flush = 1'b0;
      check(walk_req == 1'b0, "R4", "walk request dropped", 64'(walk_req), 64'(0));
   endtask

   task automatic flush_pulse();
      @(negedge clk); tlb_flush = 1'b1;
      @(negedge clk); tlb_flush = 1'b0;
   endtask

   task automatic miss_fill(logic [31:0] ea, logic [23:0] vsid, logic [19:0] ppn, string req);
      send(ea, K_MISS, 32'h0, req);
      walk({vsid, ea[27:12]}, ppn, 0);
      send(ea, K_HIT, {ppn, ea[11:0]}, req);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "response after reset", 64'(rsp_valid), 64'(0));
      check(walk_req == 1'b0, "R1", "walk after reset", 64'(walk_req), 64'(0));
      // R1: empty buffer, descriptor 0 reset to identifier 0
      miss_fill(32'h0000_1234, 24'h0, 20'h00005, "R1");

      write_sr(4'd0, 24'h000ABC, 1'b0);
      write_sr(4'd3, 24'h111111, 1'b0);
      write_sr(4'd5, 24'h111111, 1'b0);
      write_sr(4'd7, 24'h777777, 1'b0);
      write_sr(4'd9, 24'h000999, 1'b1);

      // R5/R6: fill then hit with another offset in the same page
      miss_fill(32'h0001_2345, 24'h000ABC, 20'h80001, "R5");
      send(32'h0001_2FFF, K_HIT, 32'h8000_1FFF, "R6");

      // R3: direct-store diversion
      send(32'h9ABC_DEF0, K_DS, 32'h9ABC_DEF0, "R3");
      check(walk_req == 1'b0, "R3", "walk after direct-store", 64'(walk_req), 64'(0));

      // R2: two segments sharing one identifier share the entry
      miss_fill(32'h3004_5678, 24'h111111, 20'h12345, "R2");
      send(32'h5004_5000, K_HIT, 32'h1234_5000, "R2");

      // R7: request during an outstanding walk is dropped
      send(32'h7000_1000, K_MISS, 32'h0, "R4");
      send_ign(32'h0001_2345);
      walk({24'h777777, 16'h0001}, 20'hAAAAA, 0);
      send(32'h7000_1000, K_HIT, 32'hAAAA_A000, "R5");

      // R2: write and request in the same cycle sees the old descriptor
      send_sw(32'h7000_1004, K_HIT, 32'hAAAA_A004, "R2", 4'd7, 24'h777777, 1'b1);
      send(32'h7000_1004, K_DS, 32'h7000_1004, "R2");

      // R9: flush empties the buffer
      flush_pulse();
      miss_fill(32'h0001_2345, 24'h000ABC, 20'h80001, "R9");

      // R10: flush in the acknowledge cycle discards the refill
      send(32'h3004_5678, K_MISS, 32'h0, "R10");
      walk({24'h111111, 16'h0045}, 20'h12345, 1);
      send(32'h3004_5678, K_MISS, 32'h0, "R10");
      walk({24'h111111, 16'h0045}, 20'h12345, 0);
      send(32'h3004_5678, K_HIT, 32'h1234_5678, "R10");

      // R8: round-robin replacement
      flush_pulse();
      for (int i = 0; i < 17; i++) begin
         logic [31:0] ea;
         ea = {4'h0, 16'(16'h0100 + i), 12'h000};
         miss_fill(ea, 24'h000ABC, 20'(20'h40000 + i), "R8");
      end
      send(32'h0010_1010, K_HIT, 32'h4000_1010, "R8");
      send(32'h0010_0020, K_MISS, 32'h0, "R8");
      walk({24'h000ABC, 16'h0100}, 20'h40000, 0);

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R11", "responses outstanding", 64'(sb.size()), 64'(0));
      finish_sim();
   end
endmodule